// File: doc/BRIEF.md
# Two-Step Flash Result Assembler

This block is the digital back end of a two-step converter with an 8-bit result. Each conversion has two stages. In the coarse stage a bank of 15 comparators delivers a thermometer word, and an extra comparator line reports an input above full scale. The block reduces that word to a 4-bit code and latches it. The latched code drives an output port that feeds an external DAC, which lets the analog side form the residue.

In the fine stage a second bank of 15 comparators delivers a thermometer word for that residue. The block reduces it to the lower 4 bits and loads the combined 8-bit word into an output buffer together with a ready flag.

A one-cycle `start` pulse, accepted only while the block is idle, begins a conversion. The length of each stage is a whole number of clock cycles, set by a parameter, so the comparators and the DAC get time to settle. The output bits are the straight count of levels in both setups. With a unipolar input range this reads as natural binary. With a bipolar range the same bits read as offset binary, with 8'h80 at zero input.

Top module: `twostep_assembler`

## Requirements
- R1: Each 15-line thermometer word is reduced to the number of its asserted lines (0 to 15). A pattern with bubbles therefore decodes to its ones count, and no single bubble moves the code by more than one.
- R2: The loaded result has the coarse code in bits 7:4 and the fine code in bits 3:0.
- R3: `dac_code` shows the latched coarse code. It changes only at the edge that ends the coarse stage and then holds through the fine stage and afterwards.
- R4: The coarse inputs and `over_range` are sampled at the COARSE_CYC-th rising edge after the edge that accepts `start`. The fine word is sampled FINE_CYC edges later. Comparator values at any other edge have no effect.
- R5: `busy` rises at the edge that accepts `start` and falls at the edge that samples the fine word. A `start` pulse while `busy` is high is ignored.
- R6: `result` and `ready` are loaded at the same edge. `ready` drops at the edge that accepts the next `start`. `result` holds its value until the next load.
- R7: If `over_range` was high when the coarse stage was sampled, the loaded result is 8'hFF whatever the two codes are.
- R8: `overflow` goes high at the load of a saturated result and stays high until reset.
- R9: A synchronous active-high `rst` clears the coarse code, `result`, `ready`, `overflow` and `busy` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a conversion when idle |
| coarse_therm | input | 15 | Coarse comparator thermometer word |
| over_range | input | 1 | Above-full-scale comparator |
| fine_therm | input | 15 | Fine comparator thermometer word |
| dac_code | output | 4 | Latched coarse code for the residue DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Output buffer |
| ready | output | 1 | Output buffer holds a new result |
| overflow | output | 1 | Sticky over-range status |

## Verification
The bench changes the comparator words on every cycle during a conversion. A design that sampled one cycle early or late, or that read the coarse word again in the fine stage, would then load a wrong code. The bench also drives bubbled and all-ones patterns. A priority-encoder decode would give large jumps on these patterns, and an undersized adder would wrap at 15. It pulses `start` while a conversion is running, which would restart or corrupt the conversion if the guard were missing. It raises `over_range` at the sampling edge and at other edges, to expose saturation taken from the wrong cycle and a status bit that clears itself.

// File: rtl/twostep_assembler.sv
module twostep_assembler #(
  parameter int LINES      = 15,
  parameter int COARSE_CYC = 3,
  parameter int FINE_CYC   = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [LINES-1:0]                   coarse_therm,
  input  logic                               over_range,
  input  logic [LINES-1:0]                   fine_therm,
  output logic [$clog2(LINES+1)-1:0]         dac_code,
  output logic                               busy,
  output logic [2*$clog2(LINES+1)-1:0]       result,
  output logic                               ready,
  output logic                               overflow
);
  localparam int CW    = $clog2(LINES + 1);
  localparam int RW    = 2 * CW;
  localparam int MAXC  = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_COARSE, S_FINE} phase_t;

  function automatic logic [CW-1:0] ones(input logic [LINES-1:0] t);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < LINES; i++) n = n + {{(CW-1){1'b0}}, t[i]};
    return n;
  endfunction

  phase_t          phase;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]   coarse_q;
  logic            ovr_q;

  wire [CW-1:0] coarse_now = ones(coarse_therm);
  wire [CW-1:0] fine_now   = ones(fine_therm);
  wire coarse_end = (phase == S_COARSE) && (cnt == CNT_W'(COARSE_CYC - 1));
  wire fine_end   = (phase == S_FINE)   && (cnt == CNT_W'(FINE_CYC - 1));

  assign dac_code = coarse_q;
  assign busy     = (phase != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      coarse_q <= '0;
      ovr_q    <= 1'b0;
      result   <= '0;
      ready    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      case (phase)
        S_IDLE: if (start) begin
          phase <= S_COARSE;
          cnt   <= '0;
          ready <= 1'b0;
        end
        S_COARSE: if (coarse_end) begin
          coarse_q <= coarse_now;
          ovr_q    <= over_range;
          phase    <= S_FINE;
          cnt      <= '0;
        end else cnt <= cnt + 1'b1;
        S_FINE: if (fine_end) begin
          result <= ovr_q ? {RW{1'b1}} : {coarse_q, fine_now};
          ready  <= 1'b1;
          if (ovr_q) overflow <= 1'b1;
          phase  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

module twostep_assembler_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          ready,
  input logic          overflow,
  input logic [RW-1:0] result
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) ready |-> !busy); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) (ready && $past(ready)) |-> $stable(result)); // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst) $rose(overflow) |-> (result == {RW{1'b1}})); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!ready && !busy && !overflow && result == '0)); // R9
endmodule

bind twostep_assembler twostep_assembler_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ready(ready), .overflow(overflow), .result(result)
);

// File: tb/twostep_assembler_bench.sv
module twostep_assembler_bench;
  localparam int LINES = 15, CC = 3, FC = 2;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, over_range = 1'b0;
  logic [14:0] coarse_therm = '0, fine_therm = '0;
  logic [3:0] dac_code;
  logic [7:0] result;
  logic busy, ready, overflow;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twostep_assembler #(.LINES(LINES), .COARSE_CYC(CC), .FINE_CYC(FC)) u_twostep_assembler (
    .clk(clk), .rst(rst), .start(start), .coarse_therm(coarse_therm), .over_range(over_range),
    .fine_therm(fine_therm), .dac_code(dac_code), .busy(busy), .result(result),
    .ready(ready), .overflow(overflow));

  function automatic int popc(input logic [14:0] t);
    int n = 0;
    for (int i = 0; i < 15; i++) if (t[i]) n++;
    return n;
  endfunction

  function automatic logic [14:0] therm(input int lvl);
    logic [15:0] w = (16'd1 << lvl) - 16'd1;
    return w[14:0];
  endfunction

  // behavioural reference
  int m_phase = 0, m_cnt = 0, m_coarse = 0, m_res = 0;
  bit m_ovr = 0, m_rdy = 0, m_ovf = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_coarse = 0; m_res = 0; m_ovr = 0; m_rdy = 0; m_ovf = 0;
    end else if (m_phase == 0) begin
      if (start) begin m_phase = 1; m_cnt = 0; m_rdy = 0; end
    end else if (m_phase == 1) begin
      m_cnt++;
      if (m_cnt == CC) begin m_coarse = popc(coarse_therm); m_ovr = over_range; m_phase = 2; m_cnt = 0; end
    end else begin
      m_cnt++;
      if (m_cnt == FC) begin
        m_res = m_ovr ? 255 : m_coarse * 16 + popc(fine_therm);
        m_rdy = 1; if (m_ovr) m_ovf = 1; m_phase = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    chk("R3 dac_code", int'(dac_code), m_coarse);
    chk("R5 busy", int'(busy), int'(m_phase != 0));
    chk("R1 R2 R4 R7 result", int'(result), m_res);
    chk("R6 ready", int'(ready), int'(m_rdy));
    chk("R8 overflow", int'(overflow), int'(m_ovf));
  endtask

  task automatic convert(input logic [14:0] ct, input bit ov, input logic [14:0] ft);
    coarse_therm = ct; over_range = ov; fine_therm = ft; start = 1'b1;
    tick(); start = 1'b0;
    for (int i = 0; i < CC + FC + 2; i++) tick();
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) tick();
    chk("R9 reset result", int'(result), 0);
    chk("R9 reset ready", int'(ready), 0);
    rst = 1'b0;
    tick();
    convert(therm(15), 1'b0, therm(15));      // R2 full scale 0xFF without over-range
    convert(therm(0), 1'b0, therm(0));        // R1 zero
    convert(therm(8), 1'b0, therm(0));        // R2 bipolar midscale 0x80
    convert(15'b000_0000_0101_1111, 1'b0, 15'b000_0000_0001_1011); // R1 bubbles
    convert(therm(3), 1'b1, therm(9));        // R7 saturation, R8 set
    convert(therm(5), 1'b0, therm(2));        // R8 stays high
    // R5 start while busy ignored
    coarse_therm = therm(9); fine_therm = therm(4); start = 1'b1;
    for (int i = 0; i < CC + FC + 4; i++) begin
      tick(); start = (i == 1 || i == 3);
    end
    start = 1'b0; tick(); tick();
    // R4 inputs change every cycle; R1 random bubbles
    for (int i = 0; i < 400; i++) begin
      coarse_therm = therm($urandom_range(15)) ^ (($urandom_range(3) == 0) ? 15'(1 << $urandom_range(14)) : 15'd0);
      fine_therm   = therm($urandom_range(15));
      over_range   = ($urandom_range(9) == 0);
      start        = ($urandom_range(2) == 0);
      if (i == 200) rst = 1'b1;               // R9 mid-run reset clears overflow
      if (i == 202) rst = 1'b0;
      tick();
    end
    start = 1'b0; over_range = 1'b0;
    for (int i = 0; i < 10; i++) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule